// File: doc/BRIEF.md
# Fetch Buffer Decode Stage

This block sits between instruction fetch and the warp scheduler. It holds a one-entry fetch buffer: a program counter and the warp it belongs to. In any cycle where that buffer is valid, the block drains it into the owning warp's two-entry instruction buffer. It asks an external per-warp instruction source for the instruction at the buffered PC and writes the answer into slot 0. If an instruction was found there, it asks for the next one, one instruction size further on, and writes that into slot 1 if it exists. Every slot written adds one to the warp's in-pipeline instruction count. The fetch buffer is emptied in the same cycle.

Decode acts before fetch within a cycle. A load presented in the cycle that drains the buffer is kept, so a new PC can arrive every cycle. On the scheduler side, a pop consumes the slot at the warp's read pointer. A read port shows any warp's head slot, pointer and count, and a per-warp empty flag reports warps with nothing buffered.

Top module: `fetch_decode_stage`

## Requirements
- R1: When `fb_load` is high at a rising edge, the fetch buffer becomes valid with `fb_load_warp` and `fb_load_pc`. In the following cycle `src_req_a` is high and `src_warp`/`src_pc_a` carry the captured values.
- R2: While the fetch buffer is not valid, `src_req_a` and `src_req_b` are low and no slot, pointer or count of any warp changes.
- R3: A valid fetch buffer writes slot 0 of its warp with valid=1, present=`src_hit_a` and payload=`src_inst_a`. It adds one to that warp's count, which wraps modulo 2^CNT_W.
- R4: If the first instruction is absent (`src_hit_a`=0), slot 0 is still marked valid with present=0 and the count still rises by one. No second request is made, and slot 1 keeps its prior contents.
- R5: `src_req_b` is high only when a first instruction was obtained, with `src_pc_b` = buffered PC + ISIZE. If `src_hit_b` is then high, slot 1 is written with valid=1, present=1, payload=`src_inst_b`, and the count rises by one more.
- R6: Any slot write resets that warp's read pointer to 0.
- R7: The fetch buffer is invalid after the cycle in which it was decoded, unless a load was presented in that same cycle. In that case it holds the new load, so back-to-back loads are each decoded.
- R8: A pop to a warp whose slot at the read pointer is valid clears that slot's valid bit and toggles the pointer. A pop to a warp whose slot at the pointer is invalid changes nothing.
- R9: When a pop and a decode target the same warp in one cycle, the pop is applied first and the decode writes then take effect. The pointer ends at 0.
- R10: `ibuf_empty[w]` is high exactly when both slots of warp w are invalid. After reset every slot is invalid, every count and pointer is 0, and the fetch buffer is invalid.
- R11: The read port takes `rd_warp` and shows, with no added latency, that warp's pointer, count and the valid bit, present bit and payload of the slot the pointer selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_load | input | 1 | Load the fetch buffer this cycle |
| fb_load_warp | input | WARP_W | Warp of the loaded PC |
| fb_load_pc | input | PC_W | PC to load |
| src_req_a | output | 1 | Request for the first instruction |
| src_warp | output | WARP_W | Warp whose instruction source is queried |
| src_pc_a | output | PC_W | PC of the first instruction |
| src_hit_a | input | 1 | First instruction exists |
| src_inst_a | input | INST_W | First instruction payload |
| src_req_b | output | 1 | Request for the second instruction |
| src_pc_b | output | PC_W | PC of the second instruction |
| src_hit_b | input | 1 | Second instruction exists |
| src_inst_b | input | INST_W | Second instruction payload |
| pop_valid | input | 1 | Scheduler consumes a head slot |
| pop_warp | input | WARP_W | Warp being popped |
| rd_warp | input | WARP_W | Warp shown on the read port |
| rd_valid | output | 1 | Valid bit of the head slot |
| rd_present | output | 1 | Present bit of the head slot |
| rd_inst | output | INST_W | Payload of the head slot |
| rd_ptr | output | 1 | Read pointer of the warp |
| rd_count | output | CNT_W | In-pipeline count of the warp |
| ibuf_empty | output | NUM_WARPS | Per-warp both-slots-invalid flag |

## Verification
The bench builds the block with NUM_WARPS=4, CNT_W=4 and INST_W=40. With four warps, random loads and pops keep landing on the same warp, so same-cycle pop and fill collisions occur often. The 4-bit counts wrap many times over a few hundred cycles. The bench's instruction source gives each warp a different trace length. This produces cases where both instructions are found, only the first is found, and the first is absent.

// File: rtl/fetch_decode_pkg.sv
`timescale 1ns/1ps
package fetch_decode_pkg;

  typedef enum logic [1:0] {
    SLOT_KEEP  = 2'd0,
    SLOT_CLEAR = 2'd1,
    SLOT_LOAD  = 2'd2
  } slot_act_e;

  // number of instructions placed in one decode step
  function automatic logic [1:0] placed_count(input logic put_a, input logic put_b);
    return {1'b0, put_a} + {1'b0, put_b};
  endfunction

  // what happens to one slot this cycle: a write wins over a pop
  function automatic slot_act_e slot_action(input logic slot_idx, input logic ptr,
                                            input logic pop_ok, input logic write_here);
    if (write_here)                      return SLOT_LOAD;
    else if (pop_ok && (ptr == slot_idx)) return SLOT_CLEAR;
    else                                 return SLOT_KEEP;
  endfunction

  // next read pointer: any write resets, an accepted pop toggles
  function automatic logic ptr_step(input logic cur, input logic any_write, input logic pop_ok);
    if (any_write)   return 1'b0;
    else if (pop_ok) return ~cur;
    else             return cur;
  endfunction

endpackage

// File: rtl/dec_fetch_buf.sv
`timescale 1ns/1ps
module dec_fetch_buf #(
  parameter int WARP_W = 3,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WARP_W-1:0] load_warp,
  input  logic [PC_W-1:0]   load_pc,
  input  logic              drain,
  output logic              valid,
  output logic [WARP_W-1:0] warp,
  output logic [PC_W-1:0]   pc
);

  // decode is ordered before fetch: a load in the draining cycle survives
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      warp  <= '0;
      pc    <= '0;
    end else if (load) begin
      valid <= 1'b1;
      warp  <= load_warp;
      pc    <= load_pc;
    end else if (drain) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/dec_pair_ctrl.sv
`timescale 1ns/1ps
module dec_pair_ctrl #(
  parameter int PC_W  = 32,
  parameter int ISIZE = 16
) (
  input  logic            fb_valid,
  input  logic [PC_W-1:0] fb_pc,
  input  logic            hit_a,
  input  logic            hit_b,
  output logic            req_a,
  output logic            req_b,
  output logic [PC_W-1:0] pc_a,
  output logic [PC_W-1:0] pc_b,
  output logic            put_a,
  output logic            put_b,
  output logic            present_a
);

  localparam logic [PC_W-1:0] STEP = PC_W'(ISIZE);

  function automatic logic [PC_W-1:0] follow_pc(input logic [PC_W-1:0] base);
    return base + STEP;
  endfunction

  always_comb begin
    req_a     = fb_valid;
    pc_a      = fb_pc;
    pc_b      = follow_pc(fb_pc);
    present_a = hit_a;
    put_a     = fb_valid;
    // the second lookup depends on the first having produced an instruction
    req_b     = fb_valid & hit_a;
    put_b     = req_b & hit_b;
  end

endmodule

// File: rtl/dec_warp_ibuf.sv
`timescale 1ns/1ps
module dec_warp_ibuf
  import fetch_decode_pkg::*;
#(
  parameter int INST_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fill_a,
  input  logic                   fill_b,
  input  logic                   pres_a,
  input  logic [INST_W-1:0]      inst_a,
  input  logic [INST_W-1:0]      inst_b,
  input  logic                   pop,
  output logic [1:0]             slot_v,
  output logic [1:0]             slot_p,
  output logic [1:0][INST_W-1:0] slot_i,
  output logic                   ptr,
  output logic [CNT_W-1:0]       cnt,
  output logic                   empty
);

  logic pop_ok;
  logic any_fill;

  assign pop_ok   = pop & slot_v[ptr];
  assign any_fill = fill_a | fill_b;
  assign empty    = ~(slot_v[0] | slot_v[1]);

  for (genvar s = 0; s < 2; s++) begin : g_slot
    localparam logic IDX = (s == 1);
    slot_act_e   act;
    logic        wr_here;
    logic        wr_pres;
    logic [INST_W-1:0] wr_inst;

    if (s == 0) begin : g_first
      assign wr_here = fill_a;
      assign wr_pres = pres_a;
      assign wr_inst = inst_a;
    end else begin : g_second
      assign wr_here = fill_b;
      assign wr_pres = 1'b1;
      assign wr_inst = inst_b;
    end

    always_comb act = slot_action(IDX, ptr, pop_ok, wr_here);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_v[s] <= 1'b0;
        slot_p[s] <= 1'b0;
        slot_i[s] <= '0;
      end else begin
        case (act)
          SLOT_LOAD: begin
            slot_v[s] <= 1'b1;
            slot_p[s] <= wr_pres;
            slot_i[s] <= wr_inst;
          end
          SLOT_CLEAR: slot_v[s] <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= 1'b0;
      cnt <= '0;
    end else begin
      ptr <= ptr_step(ptr, any_fill, pop_ok);
      cnt <= cnt + CNT_W'(placed_count(fill_a, fill_b));
    end
  end

endmodule

// File: rtl/fetch_decode_stage.sv
`timescale 1ns/1ps
module fetch_decode_stage
  import fetch_decode_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int PC_W      = 32,
  parameter int INST_W    = 64,
  parameter int CNT_W     = 8,
  parameter int ISIZE     = 16,
  localparam int WARP_W   = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fb_load,
  input  logic [WARP_W-1:0]    fb_load_warp,
  input  logic [PC_W-1:0]      fb_load_pc,
  output logic                 src_req_a,
  output logic [WARP_W-1:0]    src_warp,
  output logic [PC_W-1:0]      src_pc_a,
  input  logic                 src_hit_a,
  input  logic [INST_W-1:0]    src_inst_a,
  output logic                 src_req_b,
  output logic [PC_W-1:0]      src_pc_b,
  input  logic                 src_hit_b,
  input  logic [INST_W-1:0]    src_inst_b,
  input  logic                 pop_valid,
  input  logic [WARP_W-1:0]    pop_warp,
  input  logic [WARP_W-1:0]    rd_warp,
  output logic                 rd_valid,
  output logic                 rd_present,
  output logic [INST_W-1:0]    rd_inst,
  output logic                 rd_ptr,
  output logic [CNT_W-1:0]     rd_count,
  output logic [NUM_WARPS-1:0] ibuf_empty
);

  // named internal events, observed by the bound checker
  logic              fb_valid;
  logic [WARP_W-1:0] fb_warp;
  logic [PC_W-1:0]   fb_pc;
  logic              put_a;
  logic              put_b;
  logic              present_a;

  logic [1:0]             w_v   [NUM_WARPS];
  logic [1:0]             w_p   [NUM_WARPS];
  logic [1:0][INST_W-1:0] w_i   [NUM_WARPS];
  logic                   w_ptr [NUM_WARPS];
  logic [CNT_W-1:0]       w_cnt [NUM_WARPS];

  logic [NUM_WARPS-1:0]       ptr_vec;
  logic [NUM_WARPS*CNT_W-1:0] cnt_flat;

  dec_fetch_buf #(.WARP_W(WARP_W), .PC_W(PC_W)) u_fbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fb_load),
    .load_warp (fb_load_warp),
    .load_pc   (fb_load_pc),
    .drain     (put_a),
    .valid     (fb_valid),
    .warp      (fb_warp),
    .pc        (fb_pc)
  );

  dec_pair_ctrl #(.PC_W(PC_W), .ISIZE(ISIZE)) u_pair (
    .fb_valid  (fb_valid),
    .fb_pc     (fb_pc),
    .hit_a     (src_hit_a),
    .hit_b     (src_hit_b),
    .req_a     (src_req_a),
    .req_b     (src_req_b),
    .pc_a      (src_pc_a),
    .pc_b      (src_pc_b),
    .put_a     (put_a),
    .put_b     (put_b),
    .present_a (present_a)
  );

  assign src_warp = fb_warp;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic sel;
    assign sel = (fb_warp == WARP_W'(w));

    dec_warp_ibuf #(.INST_W(INST_W), .CNT_W(CNT_W)) u_ibuf (
      .clk    (clk),
      .rst_n  (rst_n),
      .fill_a (put_a & sel),
      .fill_b (put_b & sel),
      .pres_a (present_a),
      .inst_a (src_inst_a),
      .inst_b (src_inst_b),
      .pop    (pop_valid & (pop_warp == WARP_W'(w))),
      .slot_v (w_v[w]),
      .slot_p (w_p[w]),
      .slot_i (w_i[w]),
      .ptr    (w_ptr[w]),
      .cnt    (w_cnt[w]),
      .empty  (ibuf_empty[w])
    );

    assign ptr_vec[w]                 = w_ptr[w];
    assign cnt_flat[w*CNT_W +: CNT_W] = w_cnt[w];
  end

  // read port: head slot of the selected warp
  always_comb begin
    rd_ptr     = w_ptr[rd_warp];
    rd_count   = w_cnt[rd_warp];
    rd_valid   = w_v[rd_warp][rd_ptr];
    rd_present = w_p[rd_warp][rd_ptr];
    rd_inst    = w_i[rd_warp][rd_ptr];
  end

endmodule

// File: rtl/fetch_decode_stage_chk.sv
`timescale 1ns/1ps
module fetch_decode_stage_chk #(
  parameter int NUM_WARPS = 8,
  parameter int CNT_W     = 8,
  parameter int WARP_W    = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fb_load,
  input logic                       fb_valid,
  input logic [WARP_W-1:0]          fb_warp,
  input logic                       src_req_a,
  input logic                       src_req_b,
  input logic                       src_hit_a,
  input logic                       put_b,
  input logic [NUM_WARPS-1:0]       ptr_vec,
  input logic [NUM_WARPS*CNT_W-1:0] cnt_flat,
  input logic [NUM_WARPS-1:0]       ibuf_empty
);

  logic [CNT_W-1:0] cnt_of_fb;
  assign cnt_of_fb = cnt_flat[fb_warp*CNT_W +: CNT_W];

  // R7
  fb_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid && !fb_load |=> !fb_valid);

  // R2
  idle_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_valid |-> !src_req_a && !src_req_b);

  // R5
  second_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_req_b |-> src_req_a && src_hit_a);

  // R6
  ptr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |=> ptr_vec[$past(fb_warp)] == 1'b0);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |=> cnt_flat[$past(fb_warp)*CNT_W +: CNT_W] ==
                 $past(cnt_of_fb) + CNT_W'(1) + CNT_W'($past(put_b)));

  // R10
  filled_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |=> !ibuf_empty[$past(fb_warp)]);

endmodule

bind fetch_decode_stage fetch_decode_stage_chk #(
  .NUM_WARPS (NUM_WARPS),
  .CNT_W     (CNT_W),
  .WARP_W    (WARP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fb_load    (fb_load),
  .fb_valid   (fb_valid),
  .fb_warp    (fb_warp),
  .src_req_a  (src_req_a),
  .src_req_b  (src_req_b),
  .src_hit_a  (src_hit_a),
  .put_b      (put_b),
  .ptr_vec    (ptr_vec),
  .cnt_flat   (cnt_flat),
  .ibuf_empty (ibuf_empty)
);

// File: tb/fetch_decode_stage_test.sv
`timescale 1ns/1ps
module fetch_decode_stage_test;

  localparam int NW = 4;
  localparam int WW = 2;
  localparam int PW = 16;
  localparam int IW = 40;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fb_load = 1'b0;
  logic [WW-1:0] fb_load_warp = '0;
  logic [PW-1:0] fb_load_pc = '0;
  logic          src_req_a, src_req_b, src_hit_a, src_hit_b;
  logic [WW-1:0] src_warp;
  logic [PW-1:0] src_pc_a, src_pc_b;
  logic [IW-1:0] src_inst_a, src_inst_b;
  logic          pop_valid = 1'b0;
  logic [WW-1:0] pop_warp = '0;
  logic [WW-1:0] rd_warp = '0;
  logic          rd_valid, rd_present, rd_ptr;
  logic [IW-1:0] rd_inst;
  logic [CW-1:0] rd_count;
  logic [NW-1:0] ibuf_empty;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fetch_decode_stage #(.NUM_WARPS(NW), .PC_W(PW), .INST_W(IW), .CNT_W(CW), .ISIZE(16)) uut (
    .clk(clk), .rst_n(rst_n),
    .fb_load(fb_load), .fb_load_warp(fb_load_warp), .fb_load_pc(fb_load_pc),
    .src_req_a(src_req_a), .src_warp(src_warp), .src_pc_a(src_pc_a),
    .src_hit_a(src_hit_a), .src_inst_a(src_inst_a),
    .src_req_b(src_req_b), .src_pc_b(src_pc_b),
    .src_hit_b(src_hit_b), .src_inst_b(src_inst_b),
    .pop_valid(pop_valid), .pop_warp(pop_warp), .rd_warp(rd_warp),
    .rd_valid(rd_valid), .rd_present(rd_present), .rd_inst(rd_inst),
    .rd_ptr(rd_ptr), .rd_count(rd_count), .ibuf_empty(ibuf_empty)
  );

  // instruction source model: warp w has a trace of 2+2w instructions
  function automatic bit src_has(int w, int pc);
    return (pc / 16) < (2 + 2 * w);
  endfunction

  function automatic logic [IW-1:0] src_word(int w, int pc);
    return {8'(w + 8'h30), 16'(pc), 16'(pc ^ 16'h5A5A)};
  endfunction

  always_comb begin
    src_hit_a  = src_has(int'(src_warp), int'(src_pc_a));
    src_hit_b  = src_has(int'(src_warp), int'(src_pc_b));
    src_inst_a = src_word(int'(src_warp), int'(src_pc_a));
    src_inst_b = src_word(int'(src_warp), int'(src_pc_b));
  end

  // reference state
  bit            mv   [NW][2];
  bit            mpr  [NW][2];
  logic [IW-1:0] mi   [NW][2];
  bit            mptr [NW];
  int            mcnt [NW];
  bit            fbv;
  int            fbw, fbpc;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    for (int w = 0; w < NW; w++) begin
      int p;
      rd_warp = WW'(w);
      #0.3;
      p = int'(mptr[w]);
      chk(rd_ptr == mptr[w], {"R6/R11 ptr ", tag}, 64'(rd_ptr), 64'(mptr[w]));
      chk(rd_count == CW'(mcnt[w]), {"R3/R11 count ", tag}, 64'(rd_count), 64'(mcnt[w]));
      chk(rd_valid == mv[w][p], {"R11 valid ", tag}, 64'(rd_valid), 64'(mv[w][p]));
      chk(rd_present == mpr[w][p], {"R11 present ", tag}, 64'(rd_present), 64'(mpr[w][p]));
      chk(rd_inst == mi[w][p], {"R11 payload ", tag}, 64'(rd_inst), 64'(mi[w][p]));
      chk(ibuf_empty[w] == !(mv[w][0] | mv[w][1]), {"R10 empty ", tag},
          64'(ibuf_empty[w]), 64'(!(mv[w][0] | mv[w][1])));
    end
  endtask

  task automatic step(bit ld, int lw, int lpc, bit pp, int pw, string tag);
    bit a;
    fb_load = ld; fb_load_warp = WW'(lw); fb_load_pc = PW'(lpc);
    pop_valid = pp; pop_warp = WW'(pw);
    #1;
    chk(src_req_a == fbv, {"R1/R2 req_a ", tag}, 64'(src_req_a), 64'(fbv));
    if (fbv) begin
      chk(src_warp == WW'(fbw), {"R1 warp ", tag}, 64'(src_warp), 64'(fbw));
      chk(src_pc_a == PW'(fbpc), {"R1 pc_a ", tag}, 64'(src_pc_a), 64'(fbpc));
      chk(src_req_b == src_has(fbw, fbpc), {"R5 req_b ", tag}, 64'(src_req_b), 64'(src_has(fbw, fbpc)));
      if (src_req_b)
        chk(src_pc_b == PW'(fbpc + 16), {"R5 pc_b ", tag}, 64'(src_pc_b), 64'(fbpc + 16));
    end else begin
      chk(src_req_b == 1'b0, {"R2 req_b ", tag}, 64'(src_req_b), 64'd0);
    end
    @(posedge clk);
    if (pp && mv[pw][mptr[pw]]) begin
      mv[pw][mptr[pw]] = 1'b0;
      mptr[pw] = ~mptr[pw];
    end
    if (fbv) begin
      a = src_has(fbw, fbpc);
      mv[fbw][0] = 1'b1; mpr[fbw][0] = a; mi[fbw][0] = src_word(fbw, fbpc);
      mcnt[fbw] = (mcnt[fbw] + 1) % 16;
      mptr[fbw] = 1'b0;
      if (a && src_has(fbw, fbpc + 16)) begin
        mv[fbw][1] = 1'b1; mpr[fbw][1] = 1'b1; mi[fbw][1] = src_word(fbw, fbpc + 16);
        mcnt[fbw] = (mcnt[fbw] + 1) % 16;
      end
    end
    fbv = ld; fbw = lw; fbpc = lpc;
    @(negedge clk);
    fb_load = 1'b0; pop_valid = 1'b0;
    check_all(tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int w = 0; w < NW; w++) begin
      mv[w] = '{0, 0}; mpr[w] = '{0, 0}; mi[w] = '{'0, '0};
      mptr[w] = 0; mcnt[w] = 0;
    end
    fbv = 0; fbw = 0; fbpc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R10 reset");
    chk(src_req_a == 1'b0, "R10 reset fb invalid", 64'(src_req_a), 64'd0);

    step(0, 0, 0, 0, 0, "R2 idle");
    step(1, 1, 0, 0, 0, "R1 load");
    step(0, 0, 0, 0, 0, "R5 two placed");
    step(0, 0, 0, 1, 1, "R8 pop first");
    step(0, 0, 0, 1, 1, "R8 pop second");
    step(0, 0, 0, 1, 1, "R8 pop empty ignored");
    step(1, 0, 16, 0, 0, "R7 load");
    step(1, 0, 32, 0, 0, "R5 only first, R7 back-to-back");
    step(0, 0, 0, 0, 0, "R4 absent first");
    step(0, 0, 0, 1, 0, "R8 pop after absent");
    step(1, 2, 0, 0, 0, "R1 load w2");
    step(1, 2, 32, 0, 0, "R5 w2 fill");
    step(0, 0, 0, 1, 2, "R9 pop with fill");
    step(1, 3, 112, 1, 3, "R8 pop on empty");
    step(0, 0, 0, 1, 3, "R5 last entry, R9 pop with fill");
    step(0, 0, 0, 0, 0, "R2 idle after");

    for (int i = 0; i < 500; i++) begin
      step(($urandom % 3) != 0, int'($urandom % NW), int'(($urandom % 10) * 16),
           ($urandom % 2) == 1, int'($urandom % NW), "R3 R9 random");
    end
    step(0, 0, 0, 0, 0, "R7 final drain");

    done = 1;
    finish_run();
  end

endmodule